// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two entries of a hierarchical page table kept in memory. A caller presents a virtual address with a valid/ready handshake. The walker samples the table root register at that moment and reads the first-level entry through a simple request/response memory port. If that entry is valid, it reads the second-level entry from the table the first entry names. It then reports the physical address, or a page fault together with the level that faulted, in a single-cycle result pulse.

Pages are 4 KB, so the low 12 bits of the address pass through unchanged. Bits 31:22 select one of 1024 first-level entries. Bits 21:12 select one of 1024 second-level entries. Each entry is 4 bytes. Only one walk runs at a time. The sequencer has six states:
- `WS_IDLE`: ready for a request.
- `WS_RD_L1`: presents the first-level entry read.
- `WS_WT_L1`: waits for the first-level entry.
- `WS_RD_L2`: presents the second-level entry read.
- `WS_WT_L2`: waits for the second-level entry.
- `WS_DONE`: the result pulse.

The transitions are:
- `WS_IDLE` goes to `WS_RD_L1` on an accepted request.
- `WS_RD_L1` goes to `WS_WT_L1` when the memory accepts the read.
- `WS_WT_L1` goes to `WS_RD_L2` on a valid entry, or to `WS_DONE` on an invalid one.
- `WS_RD_L2` goes to `WS_WT_L2` when the memory accepts the read.
- `WS_WT_L2` goes to `WS_DONE` on any response.
- `WS_DONE` always goes back to `WS_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `mem_req_valid` and `rsp_valid` are 0.
- R2: `req_ready` is 1 only while no walk is in progress. A `req_valid` presented while `req_ready` is 0 starts no walk and produces no result.
- R3: The first memory read goes to address `root + vaddr[31:22]*4`. Both `root` (the value of `ptbr`) and `vaddr` are sampled in the cycle the request is accepted, so later changes to `ptbr` do not affect the walk.
- R4: When the first entry is valid, the second memory read goes to address `{entry1[31:12], 12'h000} + vaddr[21:12]*4`. This is a true addition, and entry bits 11:1 are ignored.
- R5: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted on the next cycle with the same `mem_req_addr`.
- R6: When the second entry has bit 0 set, the result is `rsp_paddr = {entry2[31:12], vaddr[11:0]}` with `rsp_fault` = 0.
- R7: A first-level entry with bit 0 clear gives `rsp_fault` = 1 and `rsp_fault_lvl` = 0, and no second memory read is issued.
- R8: A second-level entry with bit 0 clear gives `rsp_fault` = 1 and `rsp_fault_lvl` = 1. Whenever `rsp_fault` is 1, `rsp_paddr` is 0.
- R9: Each accepted request produces exactly one result. `rsp_valid` is high for exactly one cycle, the cycle after the last entry response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptbr | input | 32 | Byte address of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry contents; bit 0 is the valid bit, bits 31:12 hold the frame |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 32 | Translated physical address (0 on a fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_lvl | output | 1 | Level that faulted: 0 first, 1 second |

## Verification
The walker is tried with the following inputs:
- A mid-table address.
- All-ones and all-zeros index fields, which exercise the table edges and entry address bits 11:2.
- A table root whose low bits force a carry when the scaled index is added. This separates true addition from bit merging.
- A first-level entry that is missing, which shows a fault ends the walk after one read.
- A missing second-level entry, which separates the two fault levels.

The memory model also varies its handshake stalls and response latency, to separate a request that is held from one that is retried. In one run the bench changes `ptbr` and pokes `req_valid` mid-walk, to show that the root is captured at acceptance and that busy-time requests are dropped.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_RD_L1,
        WS_WT_L1,
        WS_RD_L2,
        WS_WT_L2,
        WS_DONE
    } walk_state_e;

endpackage

// File: rtl/ptw_index_split.sv
module ptw_index_split #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic [VA_W-1:0]            vaddr,
    output logic [1:0][IDX_W-1:0]      idx,
    output logic [OFF_W-1:0]           offset
);
    // idx[0] is the first-level index (upper field), idx[1] the second-level one.
    for (genvar lv = 0; lv < 2; lv++) begin : g_lvl
        localparam int LO = OFF_W + (1 - lv) * IDX_W;
        assign idx[lv] = vaddr[LO +: IDX_W];
    end

    assign offset = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int AW        = 32,
    parameter int IDX_W     = 10,
    parameter int PTE_BYTES = 4
) (
    input  logic                  second,
    input  logic [AW-1:0]         root,
    input  logic [AW-1:0]         next_base,
    input  logic [1:0][IDX_W-1:0] idx,
    output logic [AW-1:0]         entry_addr
);
    localparam int PTE_SHIFT = $clog2(PTE_BYTES);

    logic [AW-1:0]    base_sel;
    logic [IDX_W-1:0] idx_sel;
    logic [AW-1:0]    scaled;

    always_comb begin
        base_sel   = second ? next_base : root;
        idx_sel    = second ? idx[1] : idx[0];
        scaled     = {{(AW-IDX_W){1'b0}}, idx_sel} << PTE_SHIFT;
        entry_addr = base_sel + scaled;
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import pt_walker_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        pte_ok,
    output walk_state_e state,
    output logic        req_ready,
    output logic        mem_req_valid,
    output logic        rsp_valid,
    output logic        second
);
    walk_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WS_IDLE:  if (req_valid)     nxt = WS_RD_L1;
            WS_RD_L1: if (mem_req_ready) nxt = WS_WT_L1;
            WS_WT_L1: if (mem_rsp_valid) nxt = pte_ok ? WS_RD_L2 : WS_DONE;
            WS_RD_L2: if (mem_req_ready) nxt = WS_WT_L2;
            WS_WT_L2: if (mem_rsp_valid) nxt = WS_DONE;
            WS_DONE:                     nxt = WS_IDLE;
            default:                     nxt = WS_IDLE;
        endcase
    end

    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        rsp_valid     = 1'b0;
        second        = 1'b0;
        unique case (state)
            WS_IDLE:  req_ready = 1'b1;
            WS_RD_L1: mem_req_valid = 1'b1;
            WS_WT_L1: ;
            WS_RD_L2: begin mem_req_valid = 1'b1; second = 1'b1; end
            WS_WT_L2: second = 1'b1;
            WS_DONE:  rsp_valid = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/ptw_walk_regs.sv
module ptw_walk_regs
    import pt_walker_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  walk_state_e      state,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_vaddr,
    input  logic [AW-1:0]    ptbr,
    input  logic             mem_rsp_valid,
    input  logic [AW-1:0]    mem_rsp_data,
    output logic [AW-1:0]    va_q,
    output logic [AW-1:0]    root_q,
    output logic [AW-1:0]    next_base_q,
    output logic [AW-1:0]    pa_q,
    output logic             fault_q,
    output logic             fault_lvl_q
);
    logic             take;
    logic             l1_rsp;
    logic             l2_rsp;
    logic             pte_ok;
    logic [AW-1:0]    frame;
    logic             unused_pte_bits;

    assign take            = (state == WS_IDLE) && req_valid;
    assign l1_rsp          = (state == WS_WT_L1) && mem_rsp_valid;
    assign l2_rsp          = (state == WS_WT_L2) && mem_rsp_valid;
    assign pte_ok          = mem_rsp_data[0];
    assign frame           = {mem_rsp_data[AW-1:OFF_W], {OFF_W{1'b0}}};
    assign unused_pte_bits = ^mem_rsp_data[OFF_W-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q        <= '0;
            root_q      <= '0;
            next_base_q <= '0;
            pa_q        <= '0;
            fault_q     <= 1'b0;
            fault_lvl_q <= 1'b0;
        end else if (take) begin
            va_q        <= req_vaddr;
            root_q      <= ptbr;
            pa_q        <= '0;
            fault_q     <= 1'b0;
            fault_lvl_q <= 1'b0;
        end else if (l1_rsp) begin
            if (pte_ok) begin
                next_base_q <= frame;
            end else begin
                fault_q     <= 1'b1;
                fault_lvl_q <= 1'b0;
                pa_q        <= '0;
            end
        end else if (l2_rsp) begin
            if (pte_ok) begin
                pa_q    <= frame | {{(AW-OFF_W){1'b0}}, va_q[OFF_W-1:0]};
                fault_q <= 1'b0;
            end else begin
                fault_q     <= 1'b1;
                fault_lvl_q <= 1'b1;
                pa_q        <= '0;
            end
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int PTE_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     ptbr,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [31:0]     req_vaddr,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [31:0]     mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [31:0]     mem_rsp_data,
    output logic            rsp_valid,
    output logic [31:0]     rsp_paddr,
    output logic            rsp_fault,
    output logic            rsp_fault_lvl
);
    walk_state_e          state;
    logic                 second;
    logic [VA_W-1:0]      va_q;
    logic [VA_W-1:0]      root_q;
    logic [VA_W-1:0]      next_base_q;
    logic [1:0][IDX_W-1:0] idx;
    logic [OFF_W-1:0]     unused_off;

    ptw_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .pte_ok        (mem_rsp_data[0]),
        .state         (state),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .rsp_valid     (rsp_valid),
        .second        (second)
    );

    ptw_walk_regs #(.AW(VA_W), .OFF_W(OFF_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .ptbr          (ptbr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .va_q          (va_q),
        .root_q        (root_q),
        .next_base_q   (next_base_q),
        .pa_q          (rsp_paddr),
        .fault_q       (rsp_fault),
        .fault_lvl_q   (rsp_fault_lvl)
    );

    ptw_index_split #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
        .vaddr  (va_q),
        .idx    (idx),
        .offset (unused_off)
    );

    ptw_entry_addr #(.AW(VA_W), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES)) u_eaddr (
        .second     (second),
        .root       (root_q),
        .next_base  (next_base_q),
        .idx        (idx),
        .entry_addr (mem_req_addr)
    );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault
);
    logic [11:0] off_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      off_seen <= '0;
        else if (req_valid && req_ready) off_seen <= req_vaddr[11:0];
    end

    // R2: an idle walker has no read outstanding and no result
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !rsp_valid));

    // R5: an unaccepted read is held with the same address
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6: translated addresses keep the offset of the request
    assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == off_seen));

    // R8: a fault result carries a zero address
    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0));

    // R9: the result pulse lasts one cycle
    assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind pt_walker ptw_checker u_ptw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [31:0] ptbr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_lvl;

    always #10 clk = ~clk;

    pt_walker i_pt_walker (.*);

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] addr_q [$];
    logic [33:0] res_q [$];
    int  stall_mode = 0;
    int  lat = 0;
    int  cyc = 0;
    bit  done_flag = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory responder: checks each read address in order (R3, R4, R7)
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [31:0] pend_data = '0;
    logic        held = 1'b0;
    logic [31:0] held_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend_data;
                    pend = 1'b0;
                end else cnt--;
            end
            if (held) begin
                chk(mem_req_valid && mem_req_addr == held_addr, "R5 held request",
                    {1'b0, mem_req_valid, mem_req_addr}, {2'b01, held_addr});
            end
            mem_req_ready = (stall_mode == 0) ? 1'b1 : (cyc % 3 == 2);
            cyc++;
            held = mem_req_valid && !mem_req_ready;
            held_addr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                if (addr_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected read", {2'b0, mem_req_addr}, 34'h0);
                end else begin
                    logic [31:0] e;
                    e = addr_q.pop_front();
                    chk(mem_req_addr == e, "R3/R4 entry address", {2'b0, mem_req_addr}, {2'b0, e});
                end
                pend = 1'b1;
                cnt = lat;
                pend_data = rd(mem_req_addr);
            end
        end
    end

    // monitor: compares each result against the scoreboard (R6, R7, R8, R9)
    logic prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid && prev_rsp) chk(1'b0, "R9 pulse longer than one cycle", 34'h1, 34'h0);
            if (rsp_valid) begin
                if (res_q.size() == 0) begin
                    chk(1'b0, "R9 result without request", {rsp_fault, rsp_fault_lvl, rsp_paddr}, 34'h0);
                end else begin
                    logic [33:0] e;
                    e = res_q.pop_front();
                    chk({rsp_fault, rsp_fault_lvl, rsp_paddr} == e, "R6/R7/R8 result",
                        {rsp_fault, rsp_fault_lvl, rsp_paddr}, e);
                end
            end
            prev_rsp = rsp_valid;
        end
    end

    task automatic walk(input logic [31:0] va, input int smode, input int l, input bit poke);
        logic [31:0] a1, p1, a2, p2;
        stall_mode = smode;
        lat = l;
        a1 = ptbr + {20'h0, va[31:22], 2'b00};
        p1 = rd(a1);
        addr_q.push_back(a1);
        if (!p1[0]) begin
            res_q.push_back({2'b10, 32'h0});
        end else begin
            a2 = {p1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
            p2 = rd(a2);
            addr_q.push_back(a2);
            if (!p2[0]) res_q.push_back({2'b11, 32'h0});
            else        res_q.push_back({2'b00, p2[31:12], va[11:0]});
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (poke) begin
            logic [31:0] keep;
            keep = ptbr;
            req_vaddr = 32'hDEAD_BEEF;
            ptbr = 32'h0777_7000;
            for (int k = 0; k < 2; k++) begin
                chk(req_ready == 1'b0, "R2 busy walker not ready", {33'h0, req_ready}, 34'h0);
                @(negedge clk);
            end
            req_valid = 1'b0;
            while (res_q.size() != 0) @(negedge clk);
            ptbr = keep;
        end else begin
            req_valid = 1'b0;
            while (res_q.size() != 0) @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        mem[32'h0010_0004] = 32'h0020_0FFF;
        mem[32'h0020_000C] = 32'h0ABC_D001;
        mem[32'h0010_0FFC] = 32'h0030_0001;
        mem[32'h0030_0FFC] = 32'hFEDC_B003;
        mem[32'h0010_0000] = 32'h0040_0001;
        mem[32'h0040_0000] = 32'h0000_0000;
        mem[32'h0050_1000] = 32'h0020_0001;
        mem[32'h0020_0014] = 32'h1234_5001;

        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 req_ready", {33'h0, req_ready}, 34'h1);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {33'h0, mem_req_valid}, 34'h0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", {33'h0, rsp_valid}, 34'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after release", {33'h0, req_ready}, 34'h1);

        ptbr = 32'h0010_0000;
        walk(32'h0040_3ABC, 0, 0, 1'b0);   // R6 mid-table
        walk(32'hFFFF_FFFF, 1, 2, 1'b0);   // R4 R6 top indices, stalls
        walk(32'h0000_0123, 0, 1, 1'b0);   // R8 second-level fault
        walk(32'h0080_0000, 1, 0, 1'b0);   // R7 first-level fault, single read
        walk(32'h0040_3ABC, 1, 3, 1'b1);   // R2 R3 busy poke and root change
        ptbr = 32'h0050_0800;
        walk(32'h8000_5010, 0, 0, 1'b0);   // R3 carry into root

        repeat (10) @(negedge clk);
        chk(res_q.size() == 0 && addr_q.size() == 0, "R9 all results seen",
            {2'b0, 16'(res_q.size()), 16'(addr_q.size())}, 34'h0);
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule